// File: doc/BRIEF.md
# Cascadable Multiply-Accumulate Slice

This block is a purely combinational arithmetic slice built in the shape of an FPGA DSP tile. It forms a signed product from the low 25 bits of a 30-bit A operand and an 18-bit B operand. It then adds that product to a second term, the Z term, which a code in the upper bits of the operation word selects. The Z term can be zero, the C input, the cascade input taken as it is, or the cascade input shifted right by 17 places with its sign bit copied into the top.

The 48-bit sum is driven on the result port and, with the same value, on the cascade output. Two slices can be joined by wiring the first slice's cascade output to the second slice's cascade input. In this arrangement the second slice adds its own partial product to the upper part of the first slice's partial product, and no external adder is needed.

With zero-extended operands, two such slices form an unsigned 16-by-32 multiply. The first slice multiplies by b[16:0], and the second multiplies by b[31:17] and uses the shifted cascade term.

Top module: `mac_slice`

## Requirements
- R1: `p_o` and `pcout_o` are both 48 bits wide and always carry the same value.
- R2: When `opmode_i[3:0]` is 4'b0101, the product term enters the sum. For any other value of `opmode_i[3:0]`, the product term is zero.
- R3: The product treats `a_i[24:0]` and `b_i[17:0]` as two's-complement values. The 43-bit result is sign-extended to 48 bits. `a_i[29:25]` has no effect on any output.
- R4: A Z code (`opmode_i[6:4]`) of 3'b000 makes the Z term zero.
- R5: A Z code of 3'b001 makes the Z term `pcin_i`, unshifted.
- R6: A Z code of 3'b011 makes the Z term `c_i`.
- R7: A Z code of 3'b101 makes the Z term 17 copies of `pcin_i[47]` followed by `pcin_i[47:17]`.
- R8: The Z codes 3'b010, 3'b100, 3'b110 and 3'b111 make the Z term zero.
- R9: The sum of the product term and the Z term wraps modulo 2^48. No carry-out or overflow is reported.
- R10: Two slices can be chained as follows: A = {14'b0, a[15:0]}, first B = {1'b0, b[16:0]} with opmode 7'b0000101, second B = {3'b0, b[31:17]} with opmode 7'b1010101, and the second slice's `pcin_i` taken from the first slice's `pcout_o`. Then {second p_o[30:0], first p_o[16:0]} equals the unsigned product a*b, and bits 47:31 of the second slice's p_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 30 | Multiplier operand A; only bits 24:0 are used, as a signed value |
| b_i | input | 18 | Multiplier operand B, signed |
| c_i | input | 48 | Addend selectable as the Z term |
| pcin_i | input | 48 | Cascade input from an upstream slice |
| opmode_i | input | 7 | Bits 3:0 gate the product; bits 6:4 are the Z select code |
| p_o | output | 48 | Result: product term plus Z term, modulo 2^48 |
| pcout_o | output | 48 | Cascade output, equal to p_o |

## Verification
The embedded assertions are evaluated whenever the logic settles, and they check several relations:
- the sign of a nonzero product against the operand signs;
- that the extended product and the shifted cascade term have uniformly sign-filled top bits;
- that unsupported Z codes give a zero Z term;
- that the result collapses to the product, to C, or to the cascade input when the other term is switched off.

Some behaviours can only be shown by the bench's scenarios. These are the exact numeric value of each mode, wrap-around at 2^48, the unused A bits, and whether two chained slices really reproduce a 16x32 unsigned product. The bench covers them with sweeps over every Z code and product gate, together with a long run of random and corner operand pairs on the chained pair.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OPMODE_W = 7;
  localparam int unsigned XY_W     = 4;
  localparam int unsigned ZSEL_W   = 3;

  localparam logic [XY_W-1:0] XY_MUL = 4'b0101;

  typedef enum logic [ZSEL_W-1:0] {
    Z_ZERO     = 3'b000,
    Z_PCIN     = 3'b001,
    Z_C        = 3'b011,
    Z_PCIN_SHR = 3'b101
  } zsel_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned A_MUL_W = 25,
  parameter int unsigned B_W     = 18,
  parameter int unsigned P_W     = 48
) (
  input  logic [A_MUL_W-1:0] a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [P_W-1:0]     prod_o
);
  localparam int unsigned M_W   = A_MUL_W + B_W;
  localparam int unsigned EXT_W = P_W - M_W;

  logic signed [M_W-1:0] m;

  assign m      = $signed(a_i) * $signed(b_i);
  assign prod_o = {{EXT_W{m[M_W-1]}}, m};

  // R3: nonzero product sign follows operand signs; extension is uniform
  always_comb begin
    if (a_i != '0 && b_i != '0) begin
      a_r3_prod_sign: assert (prod_o[P_W-1] == (a_i[A_MUL_W-1] ^ b_i[B_W-1]))
        else $error("product sign mismatch");
    end
    a_r3_sext_uniform: assert ($countones(prod_o[P_W-1:M_W-1]) == 0 ||
                               $countones(prod_o[P_W-1:M_W-1]) == EXT_W + 1)
      else $error("product extension not uniform");
  end
endmodule

// File: rtl/mac_xy.sv
module mac_xy
  import mac_pkg::*;
#(
  parameter int unsigned P_W = 48
) (
  input  logic [XY_W-1:0] sel_i,
  input  logic [P_W-1:0]  prod_i,
  output logic [P_W-1:0]  xy_o
);
  assign xy_o = (sel_i == XY_MUL) ? prod_i : '0;
endmodule

// File: rtl/mac_zsel.sv
module mac_zsel
  import mac_pkg::*;
#(
  parameter int unsigned P_W   = 48,
  parameter int unsigned SHIFT = 17
) (
  input  logic [ZSEL_W-1:0] code_i,
  input  logic [P_W-1:0]    c_i,
  input  logic [P_W-1:0]    pcin_i,
  output logic [P_W-1:0]    z_o
);
  logic [P_W-1:0] pcin_shr;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign pcin_shr = pcin_i;
    end else begin : g_shift
      assign pcin_shr = {{SHIFT{pcin_i[P_W-1]}}, pcin_i[P_W-1:SHIFT]};

      // R7: top SHIFT+1 bits of the shifted term are all the cascade sign
      always_comb begin
        if (code_i == Z_PCIN_SHR) begin
          a_r7_shr_sign_fill: assert ($countones(z_o[P_W-1 -: SHIFT+1]) ==
                                      (pcin_i[P_W-1] ? SHIFT + 1 : 0))
            else $error("shifted cascade sign fill wrong");
        end
      end
    end
  endgenerate

  always_comb begin
    case (code_i)
      Z_PCIN:     z_o = pcin_i;
      Z_C:        z_o = c_i;
      Z_PCIN_SHR: z_o = pcin_shr;
      default:    z_o = '0;
    endcase
  end

  // R8: unsupported codes contribute nothing
  always_comb begin
    if (code_i != Z_PCIN && code_i != Z_C && code_i != Z_PCIN_SHR) begin
      a_r8_unused_code_zero: assert (z_o == '0)
        else $error("unsupported Z code gave nonzero term");
    end
  end
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_pkg::*;
#(
  parameter int unsigned A_W        = 30,
  parameter int unsigned A_MUL_W    = 25,
  parameter int unsigned B_W        = 18,
  parameter int unsigned P_W        = 48,
  parameter int unsigned CASC_SHIFT = 17
) (
  input  logic [A_W-1:0]      a_i,
  input  logic [B_W-1:0]      b_i,
  input  logic [P_W-1:0]      c_i,
  input  logic [P_W-1:0]      pcin_i,
  input  logic [OPMODE_W-1:0] opmode_i,
  output logic [P_W-1:0]      p_o,
  output logic [P_W-1:0]      pcout_o
);
  localparam int unsigned ZLO = XY_W;

  logic [XY_W-1:0]   xy_sel;
  logic [ZSEL_W-1:0] z_code;
  logic [P_W-1:0]    prod;
  logic [P_W-1:0]    xy_term;
  logic [P_W-1:0]    z_term;
  logic [P_W-1:0]    sum;
  logic              unused_a_hi;

  assign xy_sel      = opmode_i[XY_W-1:0];
  assign z_code      = opmode_i[ZLO +: ZSEL_W];
  assign unused_a_hi = ^a_i[A_W-1:A_MUL_W];

  mac_mult #(
    .A_MUL_W (A_MUL_W),
    .B_W     (B_W),
    .P_W     (P_W)
  ) u_mult (
    .a_i    (a_i[A_MUL_W-1:0]),
    .b_i    (b_i),
    .prod_o (prod)
  );

  mac_xy #(
    .P_W (P_W)
  ) u_xy (
    .sel_i  (xy_sel),
    .prod_i (prod),
    .xy_o   (xy_term)
  );

  mac_zsel #(
    .P_W   (P_W),
    .SHIFT (CASC_SHIFT)
  ) u_zsel (
    .code_i (z_code),
    .c_i    (c_i),
    .pcin_i (pcin_i),
    .z_o    (z_term)
  );

  // modulo 2^P_W; carry discarded
  assign sum     = xy_term + z_term;
  assign p_o     = sum;
  assign pcout_o = sum;

  always_comb begin
    // R4: zero Z term leaves the gated product
    if (z_code == Z_ZERO) begin
      a_r4_zero_z_passes_xy: assert (p_o == xy_term)
        else $error("zero Z term altered result");
    end
    // R2: product gated off with zero Z gives zero
    if (xy_sel != XY_MUL && z_code == Z_ZERO) begin
      a_r2_gate_off_zero: assert (p_o == '0)
        else $error("gated product leaked");
    end
    // R5: cascade passes through when product off
    if (xy_sel != XY_MUL && z_code == Z_PCIN) begin
      a_r5_pcin_pass: assert (p_o == pcin_i)
        else $error("cascade pass-through wrong");
    end
    // R6: C passes through when product off
    if (xy_sel != XY_MUL && z_code == Z_C) begin
      a_r6_c_pass: assert (p_o == c_i)
        else $error("C pass-through wrong");
    end
  end
endmodule

// File: tb/tb_mac_slice.sv
module tb_mac_slice;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  logic [29:0] a;
  logic [17:0] b;
  logic [47:0] c;
  logic [47:0] pcin;
  logic [6:0]  op;
  logic [47:0] p;
  logic [47:0] pcout;

  logic [29:0] a_hi;
  logic [17:0] b_hi;
  logic [6:0]  op_hi;
  logic [47:0] p_hi;
  logic [47:0] pcout_hi;

  mac_slice dut (
    .a_i      (a),
    .b_i      (b),
    .c_i      (c),
    .pcin_i   (pcin),
    .opmode_i (op),
    .p_o      (p),
    .pcout_o  (pcout)
  );

  mac_slice dut_hi (
    .a_i      (a_hi),
    .b_i      (b_hi),
    .c_i      (48'h0),
    .pcin_i   (pcout),
    .opmode_i (op_hi),
    .p_o      (p_hi),
    .pcout_o  (pcout_hi)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] model(input logic [29:0] fa, input logic [17:0] fb,
                                        input logic [47:0] fc, input logic [47:0] fp,
                                        input logic [6:0] fop);
    logic [47:0] pr;
    logic [47:0] zt;
    pr = {{23{fa[24]}}, fa[24:0]} * {{30{fb[17]}}, fb};
    if (fop[3:0] != 4'b0101) pr = '0;
    case (fop[6:4])
      3'b001:  zt = fp;
      3'b011:  zt = fc;
      3'b101:  zt = {{17{fp[47]}}, fp[47:17]};
      default: zt = '0;
    endcase
    return pr + zt;
  endfunction

  task automatic single(input string req, input logic [29:0] ta, input logic [17:0] tb,
                        input logic [47:0] tc, input logic [47:0] tp, input logic [6:0] top);
    logic [47:0] e;
    @(negedge clk);
    a = ta; b = tb; c = tc; pcin = tp; op = top;
    #1;
    e = model(ta, tb, tc, tp, top);
    check(req, {16'h0, p}, {16'h0, e});
    check("R1", {16'h0, pcout}, {16'h0, p});
  endtask

  task automatic chain(input logic [15:0] ca, input logic [31:0] cb);
    logic [63:0] res;
    @(negedge clk);
    a = {14'h0, ca}; b = {1'b0, cb[16:0]}; c = 48'h0; pcin = 48'h0; op = 7'b0000101;
    a_hi = {14'h0, ca}; b_hi = {3'h0, cb[31:17]}; op_hi = 7'b1010101;
    #1;
    res = {16'h0, p_hi[30:0], p[16:0]};
    check("R10 product", res, 64'(ca) * 64'(cb));
    check("R10 high zero", {47'h0, p_hi[47:31]}, 64'h0);
  endtask

  logic [3:0] nib [4] = '{4'b0101, 4'b0000, 4'b1111, 4'b0011};

  initial begin
    a = '0; b = '0; c = '0; pcin = '0; op = '0;
    a_hi = '0; b_hi = '0; op_hi = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R4 idle zero", {16'h0, p}, 64'h0);

    // every Z code against several product gates and operand sets
    for (int z = 0; z < 8; z++) begin
      for (int n = 0; n < 4; n++) begin
        for (int k = 0; k < 6; k++) begin
          logic [29:0] ta;
          logic [17:0] tb;
          logic [47:0] tc;
          logic [47:0] tp;
          logic [6:0]  top;
          string rq;
          ta = {$urandom, $urandom} & 30'h3FFF_FFFF;
          tb = 18'($urandom);
          tc = {$urandom, $urandom};
          tp = {$urandom, $urandom};
          if (k == 0) tp[47] = 1'b1;
          if (k == 1) tp[47] = 1'b0;
          if (k == 2) begin ta = 30'h0100_0000; tb = 18'h20000; end
          if (k == 3) begin ta = 30'h01FF_FFFF; tb = 18'h1FFFF; end
          top = {3'(z), nib[n]};
          case (z)
            0: rq = "R4";
            1: rq = "R5";
            3: rq = "R6";
            5: rq = "R7";
            default: rq = "R8";
          endcase
          if (n != 0) rq = {rq, "/R2"};
          single(rq, ta, tb, tc, tp, top);
        end
      end
    end

    // R3: signed corners and ignored upper A bits
    single("R3 neg*neg", 30'h0100_0000, 18'h20000, 48'h0, 48'h0, 7'b0000101);
    check("R3 neg*neg value", {16'h0, p}, 64'h0000_0200_0000_0000);
    single("R3 neg*pos", 30'h01FF_FFFF, 18'h00003, 48'h0, 48'h0, 7'b0000101);
    check("R3 neg*pos value", {16'h0, p}, {16'h0, 48'hFFFF_FFFF_FFFD});
    single("R3 upper A ignored", 30'h3E00_0007, 18'h00005, 48'h0, 48'h0, 7'b0000101);
    check("R3 upper A value", {16'h0, p}, 64'd35);

    // R9: wrap around at 2^48
    single("R9 wrap", 30'h1, 18'h1, 48'hFFFF_FFFF_FFFF, 48'h0, 7'b0110101);
    check("R9 wrap value", {16'h0, p}, 64'h0);
    single("R9 wrap pcin", 30'h2, 18'h3, 48'h0, 48'hFFFF_FFFF_FFFE, 7'b0010101);
    check("R9 wrap pcin value", {16'h0, p}, 64'h4);

    // R7 explicit value
    single("R7 shr value", 30'h0, 18'h0, 48'h0, 48'h8000_0002_0000, 7'b1010000);
    check("R7 shr exact", {16'h0, p}, {16'h0, 48'hFFFF_C000_0001});

    // R10: chained 16x32 unsigned multiply
    chain(16'h0000, 32'h0000_0000);
    chain(16'hFFFF, 32'hFFFF_FFFF);
    chain(16'hFFFF, 32'h0001_0000);
    chain(16'hFFFF, 32'h0002_0000);
    chain(16'h8001, 32'h0003_0000);
    chain(16'h0001, 32'hFFFF_FFFF);
    chain(16'hFFFF, 32'h0001_FFFF);
    for (int i = 0; i < 3000; i++) chain(16'($urandom), $urandom);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule